// File: doc/BRIEF.md
# Sequential Integer Divider with Quotient/Remainder Registers

This block divides one 32-bit integer by another over a fixed number of clock cycles and keeps the outcome in two result registers of its own: the quotient goes to `lo` and the remainder to `hi`. It sits next to the ALU and does not use the ALU's output path. A caller raises `start` for one cycle with the operands and the mode. It then waits for the single-cycle `done` pulse and reads `lo` and `hi`. Those registers keep their value until the next operation finishes.

The general path is a restoring division on operand magnitudes. It runs one step per cycle: shift the partial remainder left, subtract the divisor, and keep the difference only if it is not negative. A sign fix-up follows. In signed mode, a positive power-of-two divisor takes a shift path instead of the iteration. That path biases a negative dividend by 2^n - 1 before an arithmetic right shift, so the quotient truncates toward zero instead of rounding toward minus infinity. Every operation, including division by zero, reports after the same number of cycles.

Top module: `seq_divider`

## Requirements
- R1: An accepted start (sampled at a rising edge while `busy` is low) produces `done` high for exactly one cycle, visible after the 35th rising edge that follows the accepting edge.
- R2: `busy` is high from the cycle after the accepting edge up to the cycle before `done`. It is low while `done` is high and while the block is idle.
- R3: A `start` raised while `busy` is high is ignored. The running operation keeps its latency and its results, and the operands presented with the ignored start are never used.
- R4: In unsigned mode (`is_signed` = 0) with a non-zero divisor, `lo` is the floor quotient and `hi` is the remainder of the two operands read as unsigned numbers.
- R5: In signed mode (`is_signed` = 1) with a non-zero divisor, the quotient truncates toward zero and is negated when the operand signs differ. The remainder carries the sign of the dividend, and quotient times divisor plus remainder equals the dividend.
- R6: In signed mode with a positive power-of-two divisor 2^n, the results equal those of R5, including for negative odd dividends. For example, -1 / 2 gives quotient 0 and remainder -1, and -7 / 4 gives quotient -1 and remainder -3.
- R7: With a zero divisor, in either mode, `lo` becomes all ones and `hi` becomes the dividend, after the same latency as any other operation.
- R8: `hi` and `lo` change only on the edge that raises `done`. At all other times they hold their value.
- R9: After reset, `busy` and `done` are low and `hi` and `lo` are zero.
- R10: The signed case -2^31 / -1 gives `lo` = 0x80000000 and `hi` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only while `busy` is low |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when `hi` and `lo` have been updated |
| hi | output | 32 | Remainder register |
| lo | output | 32 | Quotient register |

## Verification
The hardest situation to create from the ports is a negative odd dividend reaching the power-of-two shift path in signed mode. Uniformly random divisors almost never land on a power of two, so the stimulus draws about a quarter of its divisors as 2^n with a random n and forces many dividends to be small negative odd numbers. A second hard case is a new request arriving while an operation is running. Directed operations raise `start` with different operands in the middle of a busy period and then confirm that the latency and results of the original operation are unchanged.

// File: rtl/seq_divider_pkg.sv
package seq_divider_pkg;

    // Where the final quotient/remainder come from.
    typedef enum logic [1:0] {
        SRC_ITER = 2'd0,   // shift/subtract iteration plus sign fix-up
        SRC_POW2 = 2'd1,   // signed divide by positive power of two
        SRC_ZERO = 2'd2    // divisor is zero
    } res_src_e;

endpackage

// File: rtl/seq_divider_prep.sv
module seq_divider_prep
    import seq_divider_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic          sgn,
    output logic [W-1:0]  mag_a,
    output logic [W-1:0]  mag_b,
    output logic          neg_quo,
    output logic          neg_rem,
    output logic [SW-1:0] shamt,
    output res_src_e      src
);
    logic a_neg, b_neg, is_pow2;

    always_comb begin
        a_neg   = sgn & op_a[W-1];
        b_neg   = sgn & op_b[W-1];
        mag_a   = a_neg ? (~op_a + 1'b1) : op_a;
        mag_b   = b_neg ? (~op_b + 1'b1) : op_b;
        neg_quo = a_neg ^ b_neg;
        neg_rem = a_neg;

        shamt = '0;
        for (int i = 0; i < W; i++) begin
            if (op_b[i]) shamt = SW'(i);
        end

        is_pow2 = (op_b != '0) && ((op_b & (op_b - 1'b1)) == '0) && !op_b[W-1];

        if (op_b == '0)          src = SRC_ZERO;
        else if (sgn && is_pow2) src = SRC_POW2;
        else                     src = SRC_ITER;
    end
endmodule

// File: rtl/seq_divider_step.sv
module seq_divider_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        // shift one dividend bit into the partial remainder
        shifted = {rem_in, quo_in[W-1]};
        // subtract, then test the sign of the difference
        trial   = shifted - {1'b0, dvs};
        if (!trial[W]) begin
            rem_out = trial[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/seq_divider_pow2.sv
module seq_divider_pow2 #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  num,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  quo,
    output logic [W-1:0]  rem
);
    logic [W-1:0] bias;
    logic [W-1:0] biased;

    always_comb begin
        // negative dividends get 2^n - 1 added so the shift truncates toward zero
        bias   = num[W-1] ? ((W'(1) << shamt) - 1'b1) : '0;
        biased = num + bias;
        quo    = W'($signed(biased) >>> shamt);
        rem    = num - (quo << shamt);
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import seq_divider_pkg::*;
#(
    parameter int W       = 32,
    parameter int LATENCY = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int SW = $clog2(W);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] FIX_C  = CW'(W);
    localparam logic [CW-1:0] LAST_C = CW'(LATENCY - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        res_src_e      src;
        logic          neg_quo;
        logic          neg_rem;
        logic [SW-1:0] shamt;
        logic [W-1:0]  raw_a;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [W-1:0]  q_res;
        logic [W-1:0]  r_res;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0]  in_mag_a, in_mag_b;
    logic          in_neg_quo, in_neg_rem;
    logic [SW-1:0] in_shamt;
    res_src_e      in_src;
    logic [W-1:0]  step_rem, step_quo;
    logic [W-1:0]  p2_quo, p2_rem;

    seq_divider_prep #(.W(W)) u_prep (
        .op_a    (dividend),
        .op_b    (divisor),
        .sgn     (is_signed),
        .mag_a   (in_mag_a),
        .mag_b   (in_mag_b),
        .neg_quo (in_neg_quo),
        .neg_rem (in_neg_rem),
        .shamt   (in_shamt),
        .src     (in_src)
    );

    seq_divider_step #(.W(W)) u_step (
        .rem_in  (st_q.rem),
        .quo_in  (st_q.quo),
        .dvs     (st_q.dvs),
        .rem_out (step_rem),
        .quo_out (step_quo)
    );

    seq_divider_pow2 #(.W(W)) u_pow2 (
        .num   (st_q.raw_a),
        .shamt (st_q.shamt),
        .quo   (p2_quo),
        .rem   (p2_rem)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.cnt     = '0;
                st_d.src     = in_src;
                st_d.neg_quo = in_neg_quo;
                st_d.neg_rem = in_neg_rem;
                st_d.shamt   = in_shamt;
                st_d.raw_a   = dividend;
                st_d.rem     = '0;
                st_d.quo     = in_mag_a;
                st_d.dvs     = in_mag_b;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if ((st_q.cnt < FIX_C) && (st_q.src == SRC_ITER)) begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
            end
            if (st_q.cnt == FIX_C) begin
                unique case (st_q.src)
                    SRC_ZERO: begin
                        st_d.q_res = '1;
                        st_d.r_res = st_q.raw_a;
                    end
                    SRC_POW2: begin
                        st_d.q_res = p2_quo;
                        st_d.r_res = p2_rem;
                    end
                    default: begin
                        st_d.q_res = st_q.neg_quo ? (~st_q.quo + 1'b1) : st_q.quo;
                        st_d.r_res = st_q.neg_rem ? (~st_q.rem + 1'b1) : st_q.rem;
                    end
                endcase
            end
            if (st_q.cnt == LAST_C) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.hi   = st_q.r_res;
                st_d.lo   = st_q.q_res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign hi   = st_q.hi;
    assign lo   = st_q.lo;

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R1
    start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.cnt == '0));

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (st_q.cnt != LAST_C)) |=> st_q.busy);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start && (st_q.cnt != LAST_C)) |=> (st_q.cnt != '0));

    // R8
    hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R7
    divzero_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && (st_q.src == SRC_ZERO)) |-> (st_q.lo == '1));
endmodule

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int checks = 0;
    int failures = 0;

    seq_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input [31:0] a, input [31:0] b, input bit sgn,
                                  output [31:0] q, output [31:0] r);
        longint sa, sb, qq, rr;
        if (b == 0) begin
            q = '1;
            r = a;
        end else if (!sgn) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            qq = sa / sb;
            rr = sa % sb;
            q  = qq[31:0];
            r  = rr[31:0];
        end
    endfunction

    // One full operation; optional start injected mid-operation.
    task automatic run_op(input [31:0] a, input [31:0] b, input bit sgn,
                          input bit inject, input string req);
        logic [31:0] eq, er;
        int n;
        bit busy_ok;
        model(a, b, sgn, eq, er);
        @(negedge clk);
        dividend = a; divisor = b; is_signed = sgn; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        dividend = $urandom; divisor = $urandom;
        n = 0;
        busy_ok = 1'b1;
        while (!done && n < 100) begin
            if (!busy) busy_ok = 1'b0;
            if (inject && n == 10) begin
                start = 1'b1; dividend = 32'h7; divisor = 32'h3; is_signed = ~sgn;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n == 35, inject ? "R3 latency" : "R1 latency", n, 35);
        chk(busy_ok && !busy, "R2 busy", {31'd0, busy}, 0);
        chk(lo == eq, {req, " lo"}, lo, eq);
        chk(hi == er, {req, " hi"}, hi, er);
        @(negedge clk);
        chk(!done, "R1 pulse", {31'd0, done}, 0);
        dividend = $urandom; divisor = $urandom;
        @(negedge clk);
        chk(lo == eq && hi == er && !busy, "R8 hold", lo, eq);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R9 flags", {30'd0, busy, done}, 0);
        chk(hi == 0 && lo == 0, "R9 regs", lo | hi, 0);

        run_op(32'd100, 32'd7, 1'b0, 1'b0, "R4");
        run_op(32'hFFFF_FFFF, 32'd2, 1'b0, 1'b0, "R4");
        run_op(-32'sd100, 32'd7, 1'b1, 1'b0, "R5");
        run_op(32'd100, -32'sd7, 1'b1, 1'b0, "R5");
        run_op(-32'sd100, -32'sd7, 1'b1, 1'b0, "R5");
        run_op(-32'sd1, 32'd2, 1'b1, 1'b0, "R6");
        run_op(-32'sd3, 32'd2, 1'b1, 1'b0, "R6");
        run_op(-32'sd7, 32'd4, 1'b1, 1'b0, "R6");
        run_op(-32'sd8, 32'd4, 1'b1, 1'b0, "R6");
        run_op(32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, "R6");
        run_op(32'd12345, 32'd0, 1'b0, 1'b0, "R7");
        run_op(-32'sd5, 32'd0, 1'b1, 1'b0, "R7");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10");
        run_op(-32'sd77, 32'd5, 1'b1, 1'b1, "R3");
        run_op(32'd999, 32'd8, 1'b1, 1'b1, "R3");

        for (int k = 0; k < 60; k++) begin
            logic [31:0] a, b;
            bit sgn;
            string req;
            int kind;
            a    = $urandom;
            sgn  = $urandom_range(0, 1);
            kind = $urandom_range(0, 7);
            if (kind < 2)       b = 32'd1 << $urandom_range(0, 30);
            else if (kind < 4)  b = $urandom_range(1, 9);
            else if (kind == 4) b = 0;
            else                b = $urandom;
            if ($urandom_range(0, 2) == 0) a = -(($urandom_range(0, 500) << 1) + 1);
            if (sgn && $urandom_range(0, 3) == 0) b = -b;
            if (b == 0)          req = "R7";
            else if (!sgn)       req = "R4";
            else if (b != 0 && !b[31] && ((b & (b - 1)) == 0)) req = "R6";
            else                 req = "R5";
            run_op(a, b, sgn, 1'b0, req);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule